// File: doc/BRIEF.md
# In-Flight Instruction Queue

This block is the central holding structure of an out-of-order core. Decoded instructions enter at the tail in program order. Each entry records its functional unit, a memory-operation flag, two source operands and a renamed destination. A source whose value is not yet known keeps the rename tag of its producer (register number joined to an instance count). It picks up the value when that tag appears on the result bus or on the commit bus.

Each cycle the queue may issue one instruction whose sources are both ready and whose functional unit reports free. Memory operations win first, and within each class the entry nearest the head wins. Finished results come back over the result bus, which names the producing entry. The entry at the head retires once it has executed. Its destination value goes out on a register-file write port, and the same port serves as a broadcast for waiting sources.

Top module: `inflight_queue`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1, `disp_idx` is 0, and `iss_valid` and `cmt_valid` are 0.
- R2: An accepted dispatch writes the entry at `disp_idx` and advances `disp_idx` by one, wrapping from DEPTH-1 to 0. After DEPTH dispatches with no commit, `disp_ready` is 0. A dispatch offered while `disp_ready` is 0 is ignored, and `disp_idx` stays unchanged.
- R3: A source dispatched with its ready input set keeps the supplied value. A source dispatched with its ready input clear waits on its tag and blocks issue of its entry.
- R4: A result-bus beat with tag T and data D sets every waiting source whose tag is T to ready with value D. It also stores D as the destination value of entry `res_idx` and marks that entry executed.
- R5: `iss_valid` is raised only for a valid, not yet issued entry with both sources ready and `fu_free[fu]` set. An entry that has issued never issues again.
- R6: Among the candidates, an entry with the memory flag set beats any entry without it. Within the same class, the entry closest to the head, counting in allocation order, wins.
- R7: `cmt_valid` is 1 exactly when the head entry has executed. It presents that entry's destination tag, its register number (the tag's upper REG_W bits) and its value. The head then advances one entry per cycle in allocation order, so a younger executed entry waits behind an older unexecuted one.
- R8: A commit of tag T with value D wakes every waiting source in the queue whose tag is T.
- R9: A source dispatched not ready, whose tag equals the tag being committed in that same cycle, is stored ready with the committed value.
- R10: A commit from a full queue frees one entry, so `disp_ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid | input | 1 | Dispatch request |
| disp_mem | input | 1 | Instruction is a load or store |
| disp_fu | input | FU_W | Target functional unit number |
| disp_pc | input | PC_W | Instruction address |
| disp_s1_rdy | input | 1 | Source 1 value is available |
| disp_s1_tag | input | TAG_W | Source 1 rename tag |
| disp_s1_val | input | DATA_W | Source 1 value |
| disp_s2_rdy | input | 1 | Source 2 value is available |
| disp_s2_tag | input | TAG_W | Source 2 rename tag |
| disp_s2_val | input | DATA_W | Source 2 value |
| disp_dst_tag | input | TAG_W | Destination rename tag |
| disp_ready | output | 1 | Queue can accept a dispatch |
| disp_idx | output | IDX_W | Entry that the next dispatch fills |
| res_valid | input | 1 | Result bus beat |
| res_idx | input | IDX_W | Producing entry |
| res_tag | input | TAG_W | Destination tag of the result |
| res_data | input | DATA_W | Result value |
| fu_free | input | 2**FU_W | One bit per functional unit, set when it can accept |
| iss_valid | output | 1 | An instruction issues this cycle |
| iss_idx | output | IDX_W | Issuing entry |
| iss_fu | output | FU_W | Its functional unit |
| iss_pc | output | PC_W | Its instruction address |
| iss_s1_val | output | DATA_W | Source 1 value |
| iss_s2_val | output | DATA_W | Source 2 value |
| iss_dst_tag | output | TAG_W | Destination tag |
| cmt_valid | output | 1 | Head entry retires this cycle |
| cmt_reg | output | REG_W | Register written |
| cmt_tag | output | TAG_W | Tag broadcast to waiting sources |
| cmt_data | output | DATA_W | Value written |

## Verification
The assertions assume that the result bus only names an entry that currently holds an instruction. They also assume that renamed tags in flight are unique, so one result never matches two unrelated producers. The directed tests keep to this. Each result beat names an entry the test dispatched earlier, and every destination tag in a scenario is distinct. Functional-unit free bits stay cleared while a scenario needs entries to stay unissued, which makes the issue order follow only from the selection rule.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int REG_W  = 5;
    localparam int INST_W = 3;
    localparam int TAG_W  = REG_W + INST_W;
    localparam int DATA_W = 32;
    localparam int PC_W   = 32;
    localparam int FU_W   = 3;
    localparam int NUM_FU = 1 << FU_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } src_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [FU_W-1:0] fu;
        logic            mem;
        logic            issued;
        logic            executed;
        src_t            s1;
        src_t            s2;
        tag_t            dtag;
        data_t           dval;
    } entry_t;

    // Capture a broadcast value into a waiting source; bus A is checked first.
    function automatic src_t snoop(input src_t s,
                                   input logic a_v, input tag_t a_t, input data_t a_d,
                                   input logic b_v, input tag_t b_t, input data_t b_d);
        src_t r;
        r = s;
        if (!s.rdy && a_v && s.tag == a_t) begin
            r.rdy = 1'b1;
            r.val = a_d;
        end else if (!s.rdy && b_v && s.tag == b_t) begin
            r.rdy = 1'b1;
            r.val = b_d;
        end
        return r;
    endfunction
endpackage

// File: rtl/iq_ptrs.sv
module iq_ptrs #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic             full
);
    localparam int CNT_W = IDX_W + 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [CNT_W-1:0] count;

    assign full = (count == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= (tail == LAST) ? '0 : tail + 1'b1;
            if (pop)  head <= (head == LAST) ? '0 : head + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    assert_full_aligned_R2: assert property (@(posedge clk) disable iff (rst)
        full |-> (head == tail));
    assert_push_guarded_R2: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);
endmodule

// File: rtl/iq_select.sv
module iq_select #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] head,
    input  logic [DEPTH-1:0] cand,
    input  logic [DEPTH-1:0] is_mem,
    output logic             found,
    output logic [IDX_W-1:0] sel
);
    logic             hit_m, hit_a;
    logic [IDX_W-1:0] sel_m, sel_a;

    // Walk the entries from the head in allocation order.
    always_comb begin
        hit_m = 1'b0;
        hit_a = 1'b0;
        sel_m = '0;
        sel_a = '0;
        for (int k = 0; k < DEPTH; k++) begin
            int p;
            p = int'(head) + k;
            if (p >= DEPTH) p = p - DEPTH;
            if (cand[p] && !hit_a) begin
                hit_a = 1'b1;
                sel_a = IDX_W'(p);
            end
            if (cand[p] && is_mem[p] && !hit_m) begin
                hit_m = 1'b1;
                sel_m = IDX_W'(p);
            end
        end
    end

    assign found = hit_a;
    assign sel   = hit_m ? sel_m : sel_a;

    assert_pick_is_candidate_R5: assert property (@(posedge clk) disable iff (rst)
        found |-> cand[sel]);
    assert_mem_first_R6: assert property (@(posedge clk) disable iff (rst)
        (found && !is_mem[sel]) |-> ((cand & is_mem) == '0));
endmodule

// File: rtl/inflight_queue.sv
module inflight_queue
    import iq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              disp_valid,
    input  logic              disp_mem,
    input  logic [FU_W-1:0]   disp_fu,
    input  logic [PC_W-1:0]   disp_pc,
    input  logic              disp_s1_rdy,
    input  logic [TAG_W-1:0]  disp_s1_tag,
    input  logic [DATA_W-1:0] disp_s1_val,
    input  logic              disp_s2_rdy,
    input  logic [TAG_W-1:0]  disp_s2_tag,
    input  logic [DATA_W-1:0] disp_s2_val,
    input  logic [TAG_W-1:0]  disp_dst_tag,
    output logic              disp_ready,
    output logic [IDX_W-1:0]  disp_idx,
    input  logic              res_valid,
    input  logic [IDX_W-1:0]  res_idx,
    input  logic [TAG_W-1:0]  res_tag,
    input  logic [DATA_W-1:0] res_data,
    input  logic [NUM_FU-1:0] fu_free,
    output logic              iss_valid,
    output logic [IDX_W-1:0]  iss_idx,
    output logic [FU_W-1:0]   iss_fu,
    output logic [PC_W-1:0]   iss_pc,
    output logic [DATA_W-1:0] iss_s1_val,
    output logic [DATA_W-1:0] iss_s2_val,
    output logic [TAG_W-1:0]  iss_dst_tag,
    output logic              cmt_valid,
    output logic [REG_W-1:0]  cmt_reg,
    output logic [TAG_W-1:0]  cmt_tag,
    output logic [DATA_W-1:0] cmt_data
);
    entry_t           q [DEPTH];
    logic [DEPTH-1:0] valid;
    logic [DEPTH-1:0] cand, is_mem;
    logic [IDX_W-1:0] head, tail, sel;
    logic             full, found, push, pop;
    entry_t           new_e;

    assign push       = disp_valid && !full;
    assign disp_ready = !full;
    assign disp_idx   = tail;

    // Retirement from the head also serves as the commit broadcast.
    assign pop       = valid[head] && q[head].executed;
    assign cmt_valid = pop;
    assign cmt_tag   = q[head].dtag;
    assign cmt_data  = q[head].dval;
    assign cmt_reg   = cmt_tag[TAG_W-1:INST_W];

    iq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .head(head), .tail(tail), .full(full)
    );

    always_comb begin
        new_e          = '0;
        new_e.pc       = disp_pc;
        new_e.fu       = disp_fu;
        new_e.mem      = disp_mem;
        new_e.dtag     = disp_dst_tag;
        new_e.s1       = snoop('{rdy: disp_s1_rdy, tag: disp_s1_tag, val: disp_s1_val},
                               res_valid, res_tag, res_data, pop, cmt_tag, cmt_data);
        new_e.s2       = snoop('{rdy: disp_s2_rdy, tag: disp_s2_tag, val: disp_s2_val},
                               res_valid, res_tag, res_data, pop, cmt_tag, cmt_data);
    end

    iq_select #(.DEPTH(DEPTH)) u_sel (
        .clk(clk), .rst(rst), .head(head), .cand(cand), .is_mem(is_mem),
        .found(found), .sel(sel)
    );

    assign iss_valid   = found;
    assign iss_idx     = sel;
    assign iss_fu      = q[sel].fu;
    assign iss_pc      = q[sel].pc;
    assign iss_s1_val  = q[sel].s1.val;
    assign iss_s2_val  = q[sel].s2.val;
    assign iss_dst_tag = q[sel].dtag;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam logic [IDX_W-1:0] ME = IDX_W'(i);

        assign cand[i]   = valid[i] && !q[i].issued && q[i].s1.rdy && q[i].s2.rdy
                           && fu_free[q[i].fu];
        assign is_mem[i] = q[i].mem;

        always_ff @(posedge clk) begin
            if (rst) begin
                valid[i] <= 1'b0;
                q[i]     <= '0;
            end else if (push && tail == ME) begin
                valid[i] <= 1'b1;
                q[i]     <= new_e;
            end else begin
                if (pop && head == ME) valid[i] <= 1'b0;
                q[i].s1 <= snoop(q[i].s1, res_valid, res_tag, res_data, pop, cmt_tag, cmt_data);
                q[i].s2 <= snoop(q[i].s2, res_valid, res_tag, res_data, pop, cmt_tag, cmt_data);
                if (found && sel == ME) q[i].issued <= 1'b1;
                if (res_valid && res_idx == ME) begin
                    q[i].executed <= 1'b1;
                    q[i].dval     <= res_data;
                end
            end
        end
    end

    assert_result_target_R4: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> valid[res_idx]);
    assert_issue_valid_R5: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> valid[iss_idx]);
    assert_issue_once_R5: assert property (@(posedge clk) disable iff (rst)
        iss_valid |=> !(iss_valid && iss_idx == $past(iss_idx)));
    assert_head_moves_R7: assert property (@(posedge clk) disable iff (rst)
        cmt_valid |=> (head != $past(head)));
    assert_stall_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !disp_ready && !cmt_valid) |=> $stable(tail));
endmodule

// File: tb/inflight_queue_tb.sv
module inflight_queue_tb;
    import iq_pkg::*;
    localparam int DEPTH = 16;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic disp_valid, disp_mem, disp_s1_rdy, disp_s2_rdy;
    logic [FU_W-1:0] disp_fu;
    logic [PC_W-1:0] disp_pc;
    logic [TAG_W-1:0] disp_s1_tag, disp_s2_tag, disp_dst_tag;
    logic [DATA_W-1:0] disp_s1_val, disp_s2_val;
    logic disp_ready;
    logic [IDX_W-1:0] disp_idx;
    logic res_valid;
    logic [IDX_W-1:0] res_idx;
    logic [TAG_W-1:0] res_tag;
    logic [DATA_W-1:0] res_data;
    logic [NUM_FU-1:0] fu_free;
    logic iss_valid;
    logic [IDX_W-1:0] iss_idx;
    logic [FU_W-1:0] iss_fu;
    logic [PC_W-1:0] iss_pc;
    logic [DATA_W-1:0] iss_s1_val, iss_s2_val;
    logic [TAG_W-1:0] iss_dst_tag;
    logic cmt_valid;
    logic [REG_W-1:0] cmt_reg;
    logic [TAG_W-1:0] cmt_tag;
    logic [DATA_W-1:0] cmt_data;

    inflight_queue #(.DEPTH(DEPTH)) u_dut (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [TAG_W-1:0] tg(input int r, input int n);
        return {REG_W'(r), INST_W'(n)};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #2;
    endtask

    task automatic idle_inputs;
        disp_valid = 0; disp_mem = 0; disp_fu = '0; disp_pc = '0;
        disp_s1_rdy = 0; disp_s1_tag = '0; disp_s1_val = '0;
        disp_s2_rdy = 0; disp_s2_tag = '0; disp_s2_val = '0;
        disp_dst_tag = '0; res_valid = 0; res_idx = '0; res_tag = '0;
        res_data = '0; fu_free = '0;
    endtask

    task automatic do_reset;
        idle_inputs();
        rst = 1;
        step();
        step();
        rst = 0;
    endtask

    task automatic disp(input int pc, input int fu, input bit mem,
                        input bit r1, input logic [TAG_W-1:0] t1, input int v1,
                        input bit r2, input logic [TAG_W-1:0] t2, input int v2,
                        input logic [TAG_W-1:0] dt);
        disp_valid = 1; disp_pc = PC_W'(pc); disp_fu = FU_W'(fu); disp_mem = mem;
        disp_s1_rdy = r1; disp_s1_tag = t1; disp_s1_val = DATA_W'(v1);
        disp_s2_rdy = r2; disp_s2_tag = t2; disp_s2_val = DATA_W'(v2);
        disp_dst_tag = dt;
        step();
        disp_valid = 0;
    endtask

    task automatic result(input int idx, input logic [TAG_W-1:0] t, input int d);
        res_valid = 1; res_idx = IDX_W'(idx); res_tag = t; res_data = DATA_W'(d);
        step();
        res_valid = 0;
    endtask

    task automatic t_reset;
        do_reset();
        #1;
        chk("R1 disp_ready", disp_ready, 1);
        chk("R1 disp_idx", disp_idx, 0);
        chk("R1 iss_valid", iss_valid, 0);
        chk("R1 cmt_valid", cmt_valid, 0);
    endtask

    task automatic t_basic;
        do_reset();
        disp(32'h40, 1, 0, 1, '0, 10, 1, '0, 20, tg(3, 1));
        #1;
        chk("R2 disp_idx advance", disp_idx, 1);
        chk("R5 no issue while unit busy", iss_valid, 0);
        fu_free = 8'b0000_0010;
        #1;
        chk("R5 issue", iss_valid, 1);
        chk("R3 iss_s1_val", iss_s1_val, 10);
        chk("R3 iss_s2_val", iss_s2_val, 20);
        chk("R5 iss_dst_tag", iss_dst_tag, tg(3, 1));
        chk("R5 iss_pc", iss_pc, 32'h40);
        step();
        #1;
        chk("R5 no reissue", iss_valid, 0);
        fu_free = '0;
        result(0, tg(3, 1), 99);
        #1;
        chk("R7 cmt_valid", cmt_valid, 1);
        chk("R7 cmt_reg", cmt_reg, 3);
        chk("R7 cmt_tag", cmt_tag, tg(3, 1));
        chk("R7 cmt_data", cmt_data, 99);
        step();
        #1;
        chk("R7 retired once", cmt_valid, 0);
    endtask

    task automatic t_wakeup;
        do_reset();
        disp(1, 3, 0, 1, '0, 1, 1, '0, 2, tg(4, 1));
        disp(2, 2, 0, 0, tg(4, 1), 0, 1, '0, 5, tg(5, 1));
        fu_free = 8'b0000_0100;
        #1;
        chk("R3 waiting source blocks issue", iss_valid, 0);
        result(0, tg(4, 1), 7);
        #1;
        chk("R4 woken entry issues", iss_valid, 1);
        chk("R4 iss_idx", iss_idx, 1);
        chk("R4 captured value", iss_s1_val, 7);
        chk("R3 ready source kept", iss_s2_val, 5);
        chk("R4 executed head commits", cmt_valid, 1);
        chk("R4 destination value", cmt_data, 7);
    endtask

    task automatic t_priority;
        do_reset();
        disp(0, 0, 0, 1, '0, 0, 1, '0, 0, tg(1, 1));
        disp(1, 0, 0, 1, '0, 0, 1, '0, 0, tg(2, 1));
        disp(2, 1, 1, 1, '0, 0, 1, '0, 0, tg(3, 1));
        disp(3, 1, 1, 1, '0, 0, 1, '0, 0, tg(4, 1));
        fu_free = 8'b0000_0011;
        #1;
        chk("R6 oldest memory first", iss_idx, 2);
        step(); #1;
        chk("R6 next memory", iss_idx, 3);
        step(); #1;
        chk("R6 then oldest other", iss_idx, 0);
        step(); #1;
        chk("R6 last other", iss_idx, 1);
        step(); #1;
        chk("R5 all issued", iss_valid, 0);
    endtask

    task automatic t_full;
        do_reset();
        for (int k = 0; k < DEPTH; k++)
            disp(k, 0, 0, 1, '0, 0, 1, '0, 0, tg(k, 1));
        #1;
        chk("R2 full", disp_ready, 0);
        chk("R2 tail wrapped", disp_idx, 0);
        disp(99, 0, 0, 1, '0, 0, 1, '0, 0, tg(30, 7));
        #1;
        chk("R2 ignored while full", disp_ready, 0);
        chk("R2 tail unchanged", disp_idx, 0);
        result(1, tg(1, 1), 32'h111);
        #1;
        chk("R7 younger waits", cmt_valid, 0);
        result(0, tg(0, 1), 32'h100);
        #1;
        chk("R7 head commits", cmt_valid, 1);
        chk("R7 head value", cmt_data, 32'h100);
        step(); #1;
        chk("R7 next in order", cmt_data, 32'h111);
        chk("R7 next register", cmt_reg, 1);
        chk("R10 space after commit", disp_ready, 1);
        step(); #1;
        chk("R7 drained", cmt_valid, 0);
        chk("R10 tail stays", disp_idx, 0);
    endtask

    task automatic t_commit_bus;
        do_reset();
        disp(0, 0, 0, 1, '0, 0, 1, '0, 0, tg(1, 1));
        disp(1, 0, 0, 1, '0, 0, 1, '0, 0, tg(6, 2));
        result(1, tg(6, 2), 55);
        disp(2, 1, 0, 0, tg(6, 2), 0, 1, '0, 3, tg(7, 1));
        fu_free = 8'b0000_0110;
        #1;
        chk("R8 late consumer waits", iss_valid, 0);
        result(0, tg(1, 1), 11);
        #1;
        chk("R7 oldest commits", cmt_tag, tg(1, 1));
        step();
        #1;
        chk("R7 producer commits", cmt_tag, tg(6, 2));
        disp(3, 2, 0, 0, tg(6, 2), 0, 1, '0, 4, tg(8, 1));
        #1;
        chk("R8 woken by commit", iss_valid, 1);
        chk("R8 iss_idx", iss_idx, 2);
        chk("R8 value", iss_s1_val, 55);
        step(); #1;
        chk("R9 captured at dispatch", iss_idx, 3);
        chk("R9 value", iss_s1_val, 55);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_wakeup();
        t_priority();
        t_full();
        t_commit_bus();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule